// File: doc/BRIEF.md
# Parallel Port Floppy Mode Multiplexer

This block lets the pins of a parallel port carry floppy-disk-controller signals instead of printer signals. A two-bit mode field in a configuration register selects one of three settings. In Normal the printer port owns its pins. In single-drive floppy mode only floppy drive 1 is carried over the port pins. In dual-drive floppy mode both drive 0 and drive 1 are carried over the port pins. The block sits between the host register decoder, the parallel port core, the floppy controller core and the pad ring.

While a floppy mode is active, the parallel port core is cut off from the host. Reads of its registers return fixed values that tell software no printer cable is attached. The one exception is the data register, which returns the last byte written to it. When the floppy controller's drive-select output names a drive that is routed to the port, the native floppy output pads go to high impedance. The floppy outputs then drive the port pins, and the floppy inputs are taken from the port pins. Port operation stays unavailable until software writes Normal back.

Top module: `ppfd_mux`

## Requirements
- R1: After reset the mode is Normal, `host_rdata` is 0x00, the data echo register is 0x00, every bit of `fdc_pin_oe` is 1, and the port pins carry `core_pin_o`/`core_pin_oe` unchanged.
- R2: A `cfg_wr` at `cfg_idx` 0xF1 loads the mode from `cfg_wdata[1:0]`: 00 selects Normal, 01 single-drive floppy, 10 dual-drive floppy, and 11 is treated as Normal. Bits 7:2 are ignored, writes at any other index leave the mode unchanged, and a new mode takes effect in the cycle after the write.
- R3: In Normal (encodings 00 and 11), `core_rd` and `core_wr` follow `host_rd` and `host_wr`, and a read returns `core_rdata` as sampled in the read cycle.
- R4: In either floppy mode, `core_rd` and `core_wr` stay 0 for every host access. This holds until the mode is written back to Normal, after which core access resumes.
- R5: Every host write to address 0 (data), in any mode, stores `host_wdata` in an echo register. In a floppy mode a read of address 0 returns that stored byte.
- R6: In a floppy mode a read of address 2 (control) returns 0x04. Bit 0 is strobe = 0, bit 1 is auto-feed = 0, bit 2 is the active-low init = 1, bit 3 is select-in = 0, and bits 7:4 are 0.
- R7: In a floppy mode a read of address 1 (status) returns 0x48. Bits 2:0 are 0, bit 3 is the active-low error = 1, bit 4 is select = 0, bit 5 is paper-end = 0, bit 6 is the active-low acknowledge = 1, and bit 7 is the active-low busy = 0.
- R8: In a floppy mode a read of address 3 returns 0x00.
- R9: A drive is routed when single-drive mode is active and `fdc_ds` = 1, or when dual-drive mode is active and `fdc_ds` is 0 or 1. Drive-select values 2 and 3 are never routed, and nothing is routed in Normal.
- R10: While a drive is routed, all of `fdc_pin_oe` is 0. Port pins 0..9 carry `fdc_out[9:0]` with output enable 1, and `fdc_in` is taken from port pins 10..14. In a floppy mode with no drive routed, `fdc_pin_oe` is all 1 and port pins 0..9 have output enable 0. Whenever a floppy mode is active, pins 10..16 have output enable 0 and drive 0.
- R11: In Normal, port pin values and enables equal `core_pin_o`/`core_pin_oe`, and `fdc_in` equals `fdc_pin_i`. `fdc_pin_o` always equals `fdc_out`.
- R12: `host_rdata` loads at the clock edge where `host_rd` is sampled high and holds its value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_idx | input | 8 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| host_rd | input | 1 | Host read of a port register |
| host_wr | input | 1 | Host write of a port register |
| host_addr | input | 2 | Port register address (0 data, 1 status, 2 control, 3 spare) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| core_rd | output | 1 | Read strobe forwarded to the parallel port core |
| core_wr | output | 1 | Write strobe forwarded to the parallel port core |
| core_rdata | input | 8 | Read data of the parallel port core for `host_addr` |
| core_pin_o | input | 17 | Port pin values from the parallel port core |
| core_pin_oe | input | 17 | Port pin enables from the parallel port core |
| pp_pin_o | output | 17 | Port pad output values |
| pp_pin_oe | output | 17 | Port pad output enables |
| pp_pin_i | input | 17 | Port pad input values |
| fdc_ds | input | 2 | Drive select from the floppy controller |
| fdc_out | input | 10 | Floppy controller outputs |
| fdc_in | output | 5 | Floppy controller inputs |
| fdc_pin_o | output | 10 | Native floppy pad output values |
| fdc_pin_oe | output | 10 | Native floppy pad output enables |
| fdc_pin_i | input | 5 | Native floppy pad input values |

## Verification
The bench sweeps all four mode encodings against all four drive-select values and checks every pin, enable and read address each time. A design that treated 11 as a floppy mode, or routed drive 0 in single-drive mode, would float the native pads or drive the port pins while no drive is routed. Upper configuration bits and writes at a neighbouring index are also exercised. A design that decoded the mode too loosely would leave Normal when it should not. A sweep of written bytes, including one written in Normal before entering a floppy mode, checks the data echo. This catches an echo register that only captures in floppy mode or that returns core data. Control-register writes in a floppy mode must not reach the core, and read data must hold between reads.

// File: rtl/ppfd_pkg.sv
package ppfd_pkg;

  localparam int unsigned PP_DW = 8;
  localparam int unsigned PP_AW = 2;

  typedef enum logic [1:0] {
    PM_NORMAL = 2'b00,
    PM_ONE    = 2'b01,
    PM_TWO    = 2'b10,
    PM_RSVD   = 2'b11
  } pmode_e;

  typedef enum logic [PP_AW-1:0] {
    RA_DATA  = 2'd0,
    RA_STAT  = 2'd1,
    RA_CTRL  = 2'd2,
    RA_SPARE = 2'd3
  } preg_e;

  // Fixed "no cable" readback images
  localparam logic [PP_DW-1:0] CTRL_IMAGE  = 8'h04;
  localparam logic [PP_DW-1:0] STAT_IMAGE  = 8'h48;
  localparam logic [PP_DW-1:0] SPARE_IMAGE = 8'h00;

  function automatic logic mode_is_floppy(input pmode_e m);
    return (m == PM_ONE) || (m == PM_TWO);
  endfunction

  function automatic logic drive_on_port(input pmode_e m, input logic [1:0] ds);
    logic hit;
    unique case (m)
      PM_ONE:  hit = (ds == 2'd1);
      PM_TWO:  hit = (ds == 2'd0) || (ds == 2'd1);
      default: hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/ppfd_rst_sync.sv
module ppfd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ppfd_mode_reg.sv
module ppfd_mode_reg
  import ppfd_pkg::*;
#(
  parameter int unsigned     IDX_W   = 8,
  parameter logic [IDX_W-1:0] CFG_IDX = 8'hF1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [1:0]       cfg_field,
  output pmode_e           mode_o,
  output logic             floppy_o
);

  pmode_e mode_q;
  pmode_e mode_d;
  logic   mode_en;

  always_comb begin
    mode_en = cfg_wr && (cfg_idx == CFG_IDX);
    mode_d  = mode_q;
    if (mode_en) begin
      mode_d = pmode_e'(cfg_field);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PM_NORMAL;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  assign mode_o   = mode_q;
  assign floppy_o = mode_is_floppy(mode_q);

endmodule

// File: rtl/ppfd_readback.sv
module ppfd_readback
  import ppfd_pkg::*;
#(
  parameter int unsigned DW = PP_DW,
  parameter int unsigned AW = PP_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          floppy_i,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic [DW-1:0] core_rdata,
  output logic [DW-1:0] host_rdata,
  output logic          core_rd,
  output logic          core_wr
);

  logic [DW-1:0] echo_q;
  logic [DW-1:0] echo_d;
  logic          echo_en;
  logic [DW-1:0] rdat_q;
  logic [DW-1:0] rdat_d;
  logic          rdat_en;
  logic [DW-1:0] fake_val;

  // Echo register captures every data-register write
  always_comb begin
    echo_en = host_wr && (host_addr == RA_DATA);
    echo_d  = echo_q;
    if (echo_en) begin
      echo_d = host_wdata;
    end
  end

  // Substitute image selected by address while in floppy mode
  always_comb begin
    unique case (preg_e'(host_addr))
      RA_DATA:  fake_val = echo_q;
      RA_STAT:  fake_val = STAT_IMAGE;
      RA_CTRL:  fake_val = CTRL_IMAGE;
      default:  fake_val = SPARE_IMAGE;
    endcase
  end

  always_comb begin
    rdat_en = host_rd;
    rdat_d  = rdat_q;
    if (rdat_en) begin
      rdat_d = floppy_i ? fake_val : core_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      echo_q <= '0;
      rdat_q <= '0;
    end else begin
      if (echo_en) begin
        echo_q <= echo_d;
      end
      if (rdat_en) begin
        rdat_q <= rdat_d;
      end
    end
  end

  assign host_rdata = rdat_q;
  assign core_rd    = host_rd && !floppy_i;
  assign core_wr    = host_wr && !floppy_i;

endmodule

// File: rtl/ppfd_route.sv
module ppfd_route
  import ppfd_pkg::*;
#(
  parameter int unsigned PP_PINS   = 17,
  parameter int unsigned FDC_OUT_W = 10,
  parameter int unsigned FDC_IN_W  = 5
) (
  input  pmode_e               mode_i,
  input  logic [1:0]           fdc_ds,
  input  logic [PP_PINS-1:0]   core_pin_o,
  input  logic [PP_PINS-1:0]   core_pin_oe,
  input  logic [PP_PINS-1:0]   pp_pin_i,
  input  logic [FDC_OUT_W-1:0] fdc_out,
  input  logic [FDC_IN_W-1:0]  fdc_pin_i,
  output logic [PP_PINS-1:0]   pp_pin_o,
  output logic [PP_PINS-1:0]   pp_pin_oe,
  output logic [FDC_IN_W-1:0]  fdc_in,
  output logic [FDC_OUT_W-1:0] fdc_pin_o,
  output logic [FDC_OUT_W-1:0] fdc_pin_oe,
  output logic                 routed_o
);

  localparam int unsigned IN_LO = FDC_OUT_W;

  logic floppy;
  logic routed;

  assign floppy   = mode_is_floppy(mode_i);
  assign routed   = drive_on_port(mode_i, fdc_ds);
  assign routed_o = routed;

  for (genvar p = 0; p < PP_PINS; p++) begin : g_pin
    if (p < FDC_OUT_W) begin : g_fout
      // Floppy output carried on this port pin
      always_comb begin
        if (floppy) begin
          pp_pin_o[p]  = fdc_out[p];
          pp_pin_oe[p] = routed;
        end else begin
          pp_pin_o[p]  = core_pin_o[p];
          pp_pin_oe[p] = core_pin_oe[p];
        end
      end
    end else begin : g_fin
      // Floppy input or unused pin: receive only in floppy mode
      always_comb begin
        if (floppy) begin
          pp_pin_o[p]  = 1'b0;
          pp_pin_oe[p] = 1'b0;
        end else begin
          pp_pin_o[p]  = core_pin_o[p];
          pp_pin_oe[p] = core_pin_oe[p];
        end
      end
    end
  end

  for (genvar k = 0; k < FDC_IN_W; k++) begin : g_fdc_in
    assign fdc_in[k] = routed ? pp_pin_i[IN_LO + k] : fdc_pin_i[k];
  end

  for (genvar n = 0; n < FDC_OUT_W; n++) begin : g_native
    assign fdc_pin_o[n]  = fdc_out[n];
    assign fdc_pin_oe[n] = !routed;
  end

endmodule

// File: rtl/ppfd_mux.sv
module ppfd_mux
  import ppfd_pkg::*;
#(
  parameter int unsigned      PP_PINS   = 17,
  parameter int unsigned      FDC_OUT_W = 10,
  parameter int unsigned      FDC_IN_W  = 5,
  parameter int unsigned      IDX_W     = 8,
  parameter logic [IDX_W-1:0] CFG_IDX   = 8'hF1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic [7:0]           cfg_wdata,
  input  logic                 host_rd,
  input  logic                 host_wr,
  input  logic [1:0]           host_addr,
  input  logic [7:0]           host_wdata,
  output logic [7:0]           host_rdata,
  output logic                 core_rd,
  output logic                 core_wr,
  input  logic [7:0]           core_rdata,
  input  logic [PP_PINS-1:0]   core_pin_o,
  input  logic [PP_PINS-1:0]   core_pin_oe,
  output logic [PP_PINS-1:0]   pp_pin_o,
  output logic [PP_PINS-1:0]   pp_pin_oe,
  input  logic [PP_PINS-1:0]   pp_pin_i,
  input  logic [1:0]           fdc_ds,
  input  logic [FDC_OUT_W-1:0] fdc_out,
  output logic [FDC_IN_W-1:0]  fdc_in,
  output logic [FDC_OUT_W-1:0] fdc_pin_o,
  output logic [FDC_OUT_W-1:0] fdc_pin_oe,
  input  logic [FDC_IN_W-1:0]  fdc_pin_i
);

  logic   rst_sync_n;
  pmode_e mode_q;
  logic   floppy;
  logic   routed;

  ppfd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ppfd_mode_reg #(.IDX_W(IDX_W), .CFG_IDX(CFG_IDX)) u_mode (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_wr    (cfg_wr),
    .cfg_idx   (cfg_idx),
    .cfg_field (cfg_wdata[1:0]),
    .mode_o    (mode_q),
    .floppy_o  (floppy)
  );

  ppfd_readback #(.DW(PP_DW), .AW(PP_AW)) u_rdbk (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .floppy_i   (floppy),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .core_rdata (core_rdata),
    .host_rdata (host_rdata),
    .core_rd    (core_rd),
    .core_wr    (core_wr)
  );

  ppfd_route #(
    .PP_PINS   (PP_PINS),
    .FDC_OUT_W (FDC_OUT_W),
    .FDC_IN_W  (FDC_IN_W)
  ) u_route (
    .mode_i      (mode_q),
    .fdc_ds      (fdc_ds),
    .core_pin_o  (core_pin_o),
    .core_pin_oe (core_pin_oe),
    .pp_pin_i    (pp_pin_i),
    .fdc_out     (fdc_out),
    .fdc_pin_i   (fdc_pin_i),
    .pp_pin_o    (pp_pin_o),
    .pp_pin_oe   (pp_pin_oe),
    .fdc_in      (fdc_in),
    .fdc_pin_o   (fdc_pin_o),
    .fdc_pin_oe  (fdc_pin_oe),
    .routed_o    (routed)
  );

endmodule

// File: rtl/ppfd_mux_chk.sv
module ppfd_mux_chk #(
  parameter int unsigned      PP_PINS   = 17,
  parameter int unsigned      FDC_OUT_W = 10,
  parameter int unsigned      IDX_W     = 8,
  parameter logic [IDX_W-1:0] CFG_IDX   = 8'hF1
) (
  input logic                 clk,
  input logic                 rst_ok_n,
  input logic                 cfg_wr,
  input logic [IDX_W-1:0]     cfg_idx,
  input logic [7:0]           cfg_wdata,
  input logic                 host_rd,
  input logic                 host_wr,
  input logic [1:0]           host_addr,
  input logic [7:0]           host_rdata,
  input logic                 core_rd,
  input logic                 core_wr,
  input logic [7:0]           core_rdata,
  input logic [PP_PINS-1:0]   pp_pin_oe,
  input logic [FDC_OUT_W-1:0] fdc_pin_oe,
  input logic [1:0]           mode,
  input logic                 floppy,
  input logic                 routed
);

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (cfg_wr && cfg_idx == CFG_IDX) |=>
      (floppy == ($past(cfg_wdata[1:0]) == 2'b01 || $past(cfg_wdata[1:0]) == 2'b10))); // R2

  AST_MODE_KEEP: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !(cfg_wr && cfg_idx == CFG_IDX) |=> $stable(mode)); // R2

  AST_CORE_CUT: assert property (@(posedge clk) disable iff (!rst_ok_n)
    floppy |-> (!core_rd && !core_wr)); // R4

  AST_CORE_PASS: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !floppy |-> (core_rd == host_rd && core_wr == host_wr)); // R3

  AST_NORMAL_READ: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (host_rd && !floppy) |=> host_rdata == $past(core_rdata)); // R3

  AST_CTRL_IMAGE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (host_rd && floppy && host_addr == 2'd2) |=> host_rdata == 8'h04); // R6

  AST_STAT_IMAGE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (host_rd && floppy && host_addr == 2'd1) |=> host_rdata == 8'h48); // R7

  AST_SPARE_IMAGE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (host_rd && floppy && host_addr == 2'd3) |=> host_rdata == 8'h00); // R8

  AST_NO_ROUTE_NORMAL: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !floppy |-> !routed); // R9

  AST_PAD_EXCL: assert property (@(posedge clk) disable iff (!rst_ok_n)
    floppy |-> !(fdc_pin_oe[0] && pp_pin_oe[0])); // R10

  AST_NATIVE_OFF: assert property (@(posedge clk) disable iff (!rst_ok_n)
    routed |-> (fdc_pin_oe == '0)); // R10

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !host_rd |=> $stable(host_rdata)); // R12

endmodule

bind ppfd_mux ppfd_mux_chk #(
  .PP_PINS   (PP_PINS),
  .FDC_OUT_W (FDC_OUT_W),
  .IDX_W     (IDX_W),
  .CFG_IDX   (CFG_IDX)
) u_chk (
  .clk        (clk),
  .rst_ok_n   (rst_sync_n),
  .cfg_wr     (cfg_wr),
  .cfg_idx    (cfg_idx),
  .cfg_wdata  (cfg_wdata),
  .host_rd    (host_rd),
  .host_wr    (host_wr),
  .host_addr  (host_addr),
  .host_rdata (host_rdata),
  .core_rd    (core_rd),
  .core_wr    (core_wr),
  .core_rdata (core_rdata),
  .pp_pin_oe  (pp_pin_oe),
  .fdc_pin_oe (fdc_pin_oe),
  .mode       (mode_q),
  .floppy     (floppy),
  .routed     (routed)
);

// File: tb/ppfd_mux_tb.sv
module ppfd_mux_tb;

  localparam int PINS = 17;
  localparam int FOW  = 10;
  localparam int FIW  = 5;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cfg_wr;
  logic [7:0]      cfg_idx;
  logic [7:0]      cfg_wdata;
  logic            host_rd;
  logic            host_wr;
  logic [1:0]      host_addr;
  logic [7:0]      host_wdata;
  logic [7:0]      host_rdata;
  logic            core_rd;
  logic            core_wr;
  logic [7:0]      core_rdata;
  logic [PINS-1:0] core_pin_o;
  logic [PINS-1:0] core_pin_oe;
  logic [PINS-1:0] pp_pin_o;
  logic [PINS-1:0] pp_pin_oe;
  logic [PINS-1:0] pp_pin_i;
  logic [1:0]      fdc_ds;
  logic [FOW-1:0]  fdc_out;
  logic [FIW-1:0]  fdc_in;
  logic [FOW-1:0]  fdc_pin_o;
  logic [FOW-1:0]  fdc_pin_oe;
  logic [FIW-1:0]  fdc_pin_i;
  logic [7:0]      salt;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] echo_m;

  always #5 clk = ~clk;

  // Parallel port core model: read data depends on address
  assign core_rdata = salt ^ {6'd0, host_addr};

  ppfd_mux u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .core_rd(core_rd), .core_wr(core_wr), .core_rdata(core_rdata),
    .core_pin_o(core_pin_o), .core_pin_oe(core_pin_oe), .pp_pin_o(pp_pin_o),
    .pp_pin_oe(pp_pin_oe), .pp_pin_i(pp_pin_i), .fdc_ds(fdc_ds),
    .fdc_out(fdc_out), .fdc_in(fdc_in), .fdc_pin_o(fdc_pin_o),
    .fdc_pin_oe(fdc_pin_oe), .fdc_pin_i(fdc_pin_i)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] idx, input logic [7:0] val);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = val;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  function automatic logic [7:0] exp_read(input logic [1:0] a, input logic fl);
    if (!fl) return salt ^ {6'd0, a};
    case (a)
      2'd0: return echo_m;
      2'd1: return 8'h48;
      2'd2: return 8'h04;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rd_tag(input logic [1:0] a, input logic fl);
    if (!fl) return "R3 normal read";
    case (a)
      2'd0: return "R5 data echo";
      2'd1: return "R7 status image";
      2'd2: return "R6 control image";
      default: return "R8 spare image";
    endcase
  endfunction

  task automatic do_read(input logic [1:0] a, input logic fl);
    logic [7:0] e;
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    e = exp_read(a, fl);
    #1;
    chk(fl ? "R4 core_rd blocked" : "R3 core_rd forwarded", {31'd0, core_rd}, {31'd0, !fl});
    @(negedge clk);
    host_rd = 1'b0;
    chk(rd_tag(a, fl), {24'd0, host_rdata}, {24'd0, e});
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] v, input logic fl);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = v;
    #1;
    chk(fl ? "R4 core_wr blocked" : "R3 core_wr forwarded", {31'd0, core_wr}, {31'd0, !fl});
    @(negedge clk);
    host_wr = 1'b0;
    if (a == 2'd0) echo_m = v;
  endtask

  task automatic pin_check(input logic fl, input logic rt);
    logic [PINS-1:0] eo, eoe;
    logic [FIW-1:0]  ein;
    for (int p = 0; p < PINS; p++) begin
      if (!fl) begin
        eo[p] = core_pin_o[p]; eoe[p] = core_pin_oe[p];
      end else if (p < FOW) begin
        eo[p] = fdc_out[p]; eoe[p] = rt;
      end else begin
        eo[p] = 1'b0; eoe[p] = 1'b0;
      end
    end
    ein = rt ? pp_pin_i[FOW +: FIW] : fdc_pin_i;
    chk(fl ? "R10 port pin values" : "R11 port pin values", {15'd0, pp_pin_o}, {15'd0, eo});
    chk(fl ? "R10 port pin enables" : "R11 port pin enables", {15'd0, pp_pin_oe}, {15'd0, eoe});
    chk("R10 fdc_in source", {27'd0, fdc_in}, {27'd0, ein});
    chk("R10 native enables", {22'd0, fdc_pin_oe}, rt ? 32'd0 : {22'd0, {FOW{1'b1}}});
    chk("R11 native values", {22'd0, fdc_pin_o}, {22'd0, fdc_out});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    host_rd = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
    salt = 8'h5C; echo_m = 8'h00;
    core_pin_o = 17'h1A5C3; core_pin_oe = 17'h0F0F0; pp_pin_i = 17'h15A5A;
    fdc_ds = 2'd0; fdc_out = 10'h2B6; fdc_pin_i = 5'h13;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 rdata after reset", {24'd0, host_rdata}, 32'd0);
    #1;
    pin_check(1'b0, 1'b0);

    // R2 neighbouring index is ignored: still Normal
    cfg_write(8'hF0, 8'h01);
    cfg_write(8'hF2, 8'h02);
    do_read(2'd1, 1'b0);

    // R1 echo register resets to 0: enter floppy and read data
    cfg_write(8'hF1, 8'h01);
    do_read(2'd0, 1'b1);

    // Full sweep: every mode code x every drive select
    for (int m = 0; m < 4; m++) begin
      logic fl;
      fl = (m == 1) || (m == 2);
      cfg_write(8'hF1, {6'b101101, m[1:0]});   // R2 upper bits ignored
      for (int ds = 0; ds < 4; ds++) begin
        logic rt;
        rt = (m == 1 && ds == 1) || (m == 2 && ds <= 1);   // R9
        @(negedge clk);
        fdc_ds = ds[1:0];
        fdc_out = 10'h2B6 ^ {ds[1:0], 8'h0F};
        pp_pin_i = 17'h15A5A ^ {15'd0, ds[1:0]} ^ {ds[1:0], 15'd0};
        fdc_pin_i = 5'h13 ^ {3'd0, ds[1:0]};
        core_pin_oe = 17'h0F0F0 ^ {15'd0, ds[1:0]};
        #1;
        pin_check(fl, rt);
        salt = 8'h5C + 8'(m * 16 + ds);
        for (int a = 0; a < 4; a++) do_read(a[1:0], fl);
        do_write(2'd0, 8'h30 + 8'(m * 4 + ds), fl);
        do_write(2'd2, 8'hFF, fl);            // R4 control write must not reach core
        do_read(2'd0, fl);
      end
    end

    // R5 byte written in Normal is echoed after entering floppy mode
    cfg_write(8'hF1, 8'h00);
    do_write(2'd0, 8'hA7, 1'b0);
    cfg_write(8'hF1, 8'h02);
    do_read(2'd0, 1'b1);

    // R5 echo sweep in dual-drive mode
    for (int v = 0; v < 256; v += 7) begin
      do_write(2'd0, v[7:0], 1'b1);
      do_read(2'd0, 1'b1);
    end

    // R12 read data holds while no read happens
    salt = 8'h99;
    repeat (3) @(negedge clk);
    chk("R12 rdata hold", {24'd0, host_rdata}, {24'd0, echo_m});

    // R4 back to Normal restores core access
    cfg_write(8'hF1, 8'h00);
    do_read(2'd2, 1'b0);
    do_write(2'd1, 8'h11, 1'b0);
    #1;
    pin_check(1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule